// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Acknowledge Decode

This block gathers interrupt requests for a 68000-style processor core and reports the most urgent one as a 3-bit priority level (IPL). Two groups of sources feed it. A vector of internal peripheral requests all share priority level 4, and a fixed rank orders them within that level. Three external request pins, active low, sit on the fixed levels 1, 6 and 7. Each pin can be set on its own to be edge-triggered or level-sensitive. Level 7 cannot be masked. Levels 2, 3 and 5 have no sources.

When the core runs an interrupt acknowledge cycle, it pulses `ack_req` and gives the level being acknowledged. One cycle later the controller returns its answer. An internal source always gets a vector built by the controller. Each external level has its own setting that chooses how its vector is supplied:
- the controller builds the vector;
- the controller pulses an acknowledge strobe for that level, and the peripheral supplies its own vector;
- the controller stays silent, so that the peripheral can request an autovector.

An acknowledge at a level with nothing pending returns a fixed spurious vector. An optional bus-clear output is asserted while an interrupt is being signalled, so that other bus masters can be made to release the bus.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the outputs `ipl`, `vec_oe`, `iack` and `bclr` are all zero.
- R2: `ipl` is registered from the current pending set. It is 7 if line 7 is pending, otherwise 6 if line 6 is pending, otherwise 4 if any internal request is set, otherwise 1 if line 1 is pending, otherwise 0. The values 2, 3 and 5 never appear.
- R3: Among internal requests the lowest index wins. An acknowledge at level 4 returns the vector `{vec_base, idx[4:0]}` with `vec_oe` high, where `idx` is the winning index.
- R4: A level-sensitive external line (`ext_edge_sel` bit = 0) is pending exactly while its synchronized pin is low. Releasing the pin removes the request.
- R5: An edge-triggered line (`ext_edge_sel` bit = 1) latches a request on a falling pin edge, seen after a two-flop synchronizer. The request stays pending after the pin returns high and is cleared by an acknowledge at its level.
- R6: The external lines are indexed 0, 1 and 2 for levels 1, 6 and 7. `ext_vec_sel[2k+1:2k]` selects the vector source for line k:
  - 0 or 3: the controller drives `{vec_base, 29+k}`;
  - 1: `iack[k]` pulses and no vector is driven;
  - 2 (autovector): neither a vector nor a strobe is produced.
- R7: An acknowledge at a level with no pending source, which includes the levels 0, 2, 3 and 5, returns vector 8'h18 with `vec_oe` high and no strobe.
- R8: `bclr` is high exactly when `bclr_en` was high and the registered `ipl` is nonzero.
- R9: An acknowledge response lasts exactly one cycle: it appears on the cycle after the `ack_req` pulse and is gone on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req | input | NUM_INT | Internal requests at level 4; index 0 has the highest rank |
| ext_irq_n | input | 3 | External request pins, active low; bits map to levels 1, 6 and 7 |
| ext_edge_sel | input | 3 | Per line: 1 = edge-triggered, 0 = level-sensitive |
| ext_vec_sel | input | 6 | Per line, 2 bits: vector source select |
| vec_base | input | 3 | Upper bits of the vector built by the controller |
| bclr_en | input | 1 | Enables the bus-clear output |
| ack_req | input | 1 | One-cycle pulse marking an acknowledge cycle |
| ack_level | input | 3 | Level being acknowledged |
| ipl | output | 3 | Highest pending priority level |
| vec_out | output | 8 | Acknowledge vector |
| vec_oe | output | 1 | The controller is driving `vec_out` |
| iack | output | 3 | Per-line acknowledge strobes |
| bclr | output | 1 | Bus-clear request |

## Verification
The following properties are checked on every cycle:
- `ipl` never takes the values 2, 3 or 5, and a pending line 7 always gives level 7 on the next cycle.
- The winning internal index has no set request of lower index.
- The strobes are one-hot and never coincide with a driven vector.
- A response never appears without an acknowledge on the cycle before it.
- An edge-latched request only goes away through its acknowledge.
- `bclr` never rises without a nonzero level.

Only the bench's sweeps can show that the values are correct: the exact vector for each internal index and for each pair of internal requests, every combination of pending levels, each vector-source setting per line, the spurious answer at every level, and the difference between releasing a level-sensitive pin and releasing an edge-triggered one.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int NUM_EXT  = 3;
    localparam int VEC_W    = 8;
    localparam int LOW_W    = 5;
    localparam int BASE_W   = VEC_W - LOW_W;
    localparam int EXT_CODE0 = 29;
    localparam logic [VEC_W-1:0] SPURIOUS_VEC = 8'h18;

    typedef enum logic [1:0] {
        SRC_CTRL   = 2'd0,
        SRC_PERIPH = 2'd1,
        SRC_AUTO   = 2'd2,
        SRC_RSVD   = 2'd3
    } vec_src_e;

    typedef struct packed {
        logic               oe;
        logic [VEC_W-1:0]   vec;
        logic [NUM_EXT-1:0] strobe;
    } ack_resp_t;

    // Level of external line k (0 -> 1, 1 -> 6, 2 -> 7)
    function automatic logic [2:0] ext_level(input int k);
        case (k)
            0:       return 3'd1;
            1:       return 3'd6;
            default: return 3'd7;
        endcase
    endfunction

    // Priority order: 7, 6, internal level 4, then 1
    function automatic logic [2:0] ipl_encode(input logic [NUM_EXT-1:0] ext_pend,
                                              input logic int_any);
        if (ext_pend[2])      return 3'd7;
        else if (ext_pend[1]) return 3'd6;
        else if (int_any)     return 3'd4;
        else if (ext_pend[0]) return 3'd1;
        else                  return 3'd0;
    endfunction
endpackage

// File: rtl/irqc_ext_line.sv
`timescale 1ns/1ps
module irqc_ext_line #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic pending
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   latch_q;
    logic                   fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            prev_q <= sync_q[MSB];
        end
    end

    assign fall = prev_q & ~sync_q[MSB];

    // A new edge wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)       latch_q <= 1'b0;
        else if (fall) latch_q <= 1'b1;
        else if (clr)  latch_q <= 1'b0;
    end

    assign pending = edge_mode ? latch_q : ~sync_q[MSB];

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (latch_q && !clr) |=> latch_q);
endmodule

// File: rtl/irqc_int_rank.sv
`timescale 1ns/1ps
module irqc_int_rank #(
    parameter int NUM_INT = 16,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_INT-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = NUM_INT - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/irqc_ack_decode.sv
`timescale 1ns/1ps
module irqc_ack_decode
    import irqc_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ack_req,
    input  logic [2:0]          ack_level,
    input  logic [NUM_EXT-1:0]  ext_pend,
    input  logic [2*NUM_EXT-1:0] ext_src,
    input  logic                int_any,
    input  logic [IDX_W-1:0]    int_idx,
    input  logic [BASE_W-1:0]   vec_base,
    output logic [NUM_EXT-1:0]  ext_clr,
    output ack_resp_t           resp
);
    ack_resp_t resp_d;
    ack_resp_t resp_q;

    always_comb begin
        resp_d  = '0;
        ext_clr = '0;
        if (ack_req) begin
            resp_d.oe  = 1'b1;
            resp_d.vec = SPURIOUS_VEC;
            if (ack_level == 3'd4) begin
                if (int_any) resp_d.vec = {vec_base, LOW_W'(int_idx)};
            end else begin
                for (int k = 0; k < NUM_EXT; k++) begin
                    if (ack_level == ext_level(k) && ext_pend[k]) begin
                        ext_clr[k] = 1'b1;
                        case (vec_src_e'(ext_src[2*k +: 2]))
                            SRC_PERIPH: begin
                                resp_d.oe        = 1'b0;
                                resp_d.vec       = '0;
                                resp_d.strobe[k] = 1'b1;
                            end
                            SRC_AUTO: begin
                                resp_d.oe  = 1'b0;
                                resp_d.vec = '0;
                            end
                            default: resp_d.vec = {vec_base, LOW_W'(EXT_CODE0 + k)};
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) resp_q <= '0;
        else     resp_q <= resp_d;
    end

    assign resp = resp_q;

    p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(resp_q.strobe));
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        (|resp_q.strobe) |-> !resp_q.oe);
    p_resp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (resp_q.oe || (|resp_q.strobe)) |-> $past(ack_req));
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_INT     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_INT-1:0] int_req,
    input  logic [2:0]         ext_irq_n,
    input  logic [2:0]         ext_edge_sel,
    input  logic [5:0]         ext_vec_sel,
    input  logic [2:0]         vec_base,
    input  logic               bclr_en,
    input  logic               ack_req,
    input  logic [2:0]         ack_level,
    output logic [2:0]         ipl,
    output logic [7:0]         vec_out,
    output logic               vec_oe,
    output logic [2:0]         iack,
    output logic               bclr
);
    localparam int IDX_W = LOW_W;

    if (NUM_INT > EXT_CODE0) begin : g_bad_count
        $error("NUM_INT overlaps the external vector codes");
    end

    logic [NUM_EXT-1:0] ext_pend;
    logic [NUM_EXT-1:0] ext_clr;
    logic               int_any;
    logic [IDX_W-1:0]   int_idx;
    logic [2:0]         ipl_q;
    logic               bclr_q;
    ack_resp_t          resp;

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        irqc_ext_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
            .clk       (clk),
            .rst       (rst),
            .pin_n     (ext_irq_n[k]),
            .edge_mode (ext_edge_sel[k]),
            .clr       (ext_clr[k]),
            .pending   (ext_pend[k])
        );
    end

    irqc_int_rank #(.NUM_INT(NUM_INT), .IDX_W(IDX_W)) u_rank (
        .req (int_req),
        .any (int_any),
        .idx (int_idx)
    );

    irqc_ack_decode #(.IDX_W(IDX_W)) u_ack (
        .clk       (clk),
        .rst       (rst),
        .ack_req   (ack_req),
        .ack_level (ack_level),
        .ext_pend  (ext_pend),
        .ext_src   (ext_vec_sel),
        .int_any   (int_any),
        .int_idx   (int_idx),
        .vec_base  (vec_base),
        .ext_clr   (ext_clr),
        .resp      (resp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ipl_q  <= 3'd0;
            bclr_q <= 1'b0;
        end else begin
            ipl_q  <= ipl_encode(ext_pend, int_any);
            bclr_q <= bclr_en && (ipl_encode(ext_pend, int_any) != 3'd0);
        end
    end

    assign ipl     = ipl_q;
    assign bclr    = bclr_q;
    assign vec_out = resp.vec;
    assign vec_oe  = resp.oe;
    assign iack    = resp.strobe;

    p_ipl_legal_r2: assert property (@(posedge clk) disable iff (rst)
        !(ipl_q inside {3'd2, 3'd3, 3'd5}));
    p_ipl7_r2: assert property (@(posedge clk) disable iff (rst)
        ext_pend[2] |=> (ipl_q == 3'd7));
    p_rank_r3: assert property (@(posedge clk) disable iff (rst)
        int_any |-> ((int_req & ((NUM_INT'(1) << int_idx) - NUM_INT'(1))) == '0));
    p_bclr_r8: assert property (@(posedge clk) disable iff (rst)
        bclr_q |-> (ipl_q != 3'd0));
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    localparam int NUM_INT = 16;
    localparam logic [2:0] BASE = 3'b101;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_INT-1:0] int_req = '0;
    logic [2:0]         ext_irq_n = 3'b111;
    logic [2:0]         ext_edge_sel = 3'b000;
    logic [5:0]         ext_vec_sel = 6'd0;
    logic [2:0]         vec_base = BASE;
    logic               bclr_en = 1'b0;
    logic               ack_req = 1'b0;
    logic [2:0]         ack_level = 3'd0;
    logic [2:0]         ipl;
    logic [7:0]         vec_out;
    logic               vec_oe;
    logic [2:0]         iack;
    logic               bclr;

    int n_chk = 0;
    int n_err = 0;
    logic       r_oe;
    logic [7:0] r_vec;
    logic [2:0] r_iack;

    irq_prio_ctrl #(.NUM_INT(NUM_INT)) i_irq_prio_ctrl (
        .clk(clk), .rst(rst), .int_req(int_req), .ext_irq_n(ext_irq_n),
        .ext_edge_sel(ext_edge_sel), .ext_vec_sel(ext_vec_sel), .vec_base(vec_base),
        .bclr_en(bclr_en), .ack_req(ack_req), .ack_level(ack_level),
        .ipl(ipl), .vec_out(vec_out), .vec_oe(vec_oe), .iack(iack), .bclr(bclr)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [2:0] lvl_of(input int k);
        return (k == 0) ? 3'd1 : (k == 1) ? 3'd6 : 3'd7;
    endfunction

    function automatic logic [2:0] exp_ipl(input logic [2:0] ext, input logic ia);
        if (ext[2]) return 3'd7;
        if (ext[1]) return 3'd6;
        if (ia)     return 3'd4;
        if (ext[0]) return 3'd1;
        return 3'd0;
    endfunction

    // Pulses ack for one cycle, captures the response and checks R9 one cycle later
    task automatic do_ack(input logic [2:0] lvl);
        @(negedge clk);
        ack_req = 1'b1;
        ack_level = lvl;
        @(negedge clk);
        ack_req = 1'b0;
        r_oe = vec_oe;
        r_vec = vec_out;
        r_iack = iack;
        @(negedge clk);
        chk("R9", "response gone", {28'd0, vec_oe, iack}, 32'd0);
    endtask

    initial begin
        settle(3);
        chk("R1", "ipl in reset", ipl, 0);
        chk("R1", "oe/iack/bclr in reset", {vec_oe, iack, bclr}, 0);
        rst = 1'b0;
        bclr_en = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", {ipl, vec_oe, iack, bclr}, 0);

        // R3: every single internal source, then every pair
        for (int i = 0; i < NUM_INT; i++) begin
            int_req = NUM_INT'(1) << i;
            settle(2);
            chk("R2", "ipl internal", ipl, 4);
            do_ack(3'd4);
            chk("R3", "single vec", {r_oe, r_vec}, {1'b1, BASE, 5'(i)});
        end
        for (int i = 0; i < NUM_INT; i++) begin
            for (int j = i + 1; j < NUM_INT; j++) begin
                int_req = (NUM_INT'(1) << i) | (NUM_INT'(1) << j);
                do_ack(3'd4);
                chk("R3", "pair vec", {r_oe, r_vec}, {1'b1, BASE, 5'(i)});
            end
        end
        int_req = '0;

        // R2/R8: all combinations of level-sensitive lines and internal activity
        for (int m = 0; m < 16; m++) begin
            logic [2:0] e;
            logic [2:0] el;
            e = m[2:0];
            bclr_en = m[0] ^ m[3];
            ext_irq_n = ~e;
            int_req = m[3] ? 16'h0100 : 16'h0000;
            settle(5);
            el = exp_ipl(e, m[3]);
            chk("R2", "ipl combo", ipl, el);
            chk("R8", "bclr combo", bclr, bclr_en && (el != 0));
            do_ack(el);
            case (el)
                3'd7: chk("R6", "combo vec", {r_oe, r_vec}, {1'b1, BASE, 5'd31});
                3'd6: chk("R6", "combo vec", {r_oe, r_vec}, {1'b1, BASE, 5'd30});
                3'd4: chk("R3", "combo vec", {r_oe, r_vec}, {1'b1, BASE, 5'd8});
                3'd1: chk("R6", "combo vec", {r_oe, r_vec}, {1'b1, BASE, 5'd29});
                default: chk("R7", "combo vec", {r_oe, r_vec}, {1'b1, 8'h18});
            endcase
        end
        ext_irq_n = 3'b111;
        int_req = '0;
        bclr_en = 1'b1;
        settle(5);
        chk("R4", "released lines", ipl, 0);

        // R6: every vector source setting on every line, level-sensitive
        for (int k = 0; k < 3; k++) begin
            for (int s = 0; s < 4; s++) begin
                ext_vec_sel = {2'(s), 2'(s), 2'(s)};
                ext_irq_n = ~(3'b001 << k);
                settle(5);
                chk("R4", "level pending", ipl, lvl_of(k));
                do_ack(lvl_of(k));
                if (s == 1)
                    chk("R6", "periph strobe", {r_oe, r_iack}, {1'b0, 3'b001 << k});
                else if (s == 2)
                    chk("R6", "autovector", {r_oe, r_iack}, 0);
                else
                    chk("R6", "ctrl vec", {r_oe, r_vec, r_iack},
                        {1'b1, BASE, 5'(29 + k), 3'b000});
                ext_irq_n = 3'b111;
                settle(5);
                chk("R4", "level released", ipl, 0);
            end
        end
        ext_vec_sel = 6'd0;

        // R5: edge latch holds after release and clears on acknowledge
        ext_edge_sel = 3'b111;
        settle(3);
        for (int k = 0; k < 3; k++) begin
            ext_irq_n = ~(3'b001 << k);
            settle(3);
            ext_irq_n = 3'b111;
            settle(6);
            chk("R5", "edge held", ipl, lvl_of(k));
            do_ack(lvl_of(k));
            chk("R5", "edge vec", {r_oe, r_vec}, {1'b1, BASE, 5'(29 + k)});
            settle(3);
            chk("R5", "edge cleared", ipl, 0);
        end
        ext_edge_sel = 3'b000;

        // R7: spurious at every level with nothing pending
        for (int l = 0; l < 8; l++) begin
            do_ack(3'(l));
            chk("R7", "spurious", {r_oe, r_vec, r_iack}, {1'b1, 8'h18, 3'b000});
        end

        // R8: bclr disabled while a request is active
        bclr_en = 1'b0;
        int_req = 16'h0001;
        settle(3);
        chk("R8", "bclr disabled", {ipl, bclr}, {3'd4, 1'b0});
        bclr_en = 1'b1;
        settle(2);
        chk("R8", "bclr enabled", bclr, 1);
        int_req = '0;
        settle(2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1_500_000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule